// File: doc/BRIEF.md
# Processor Low-Power Handshake Controller

This block is the power-mode state machine of a host bridge and memory controller. Software first arms the power-management bit. After that, a quiesce request or a halt indication from the processor moves the block into a pending state. There it waits until the bridge reports idle, raises the acknowledge line, and on the following edge enters nap or sleep. A configuration select picks which of the two.

In sleep, the block watches only three wake sources: bus request 0, bus request 1 and the non-maskable interrupt. A configuration bit gates each of the last two. The block also tells the external refresh engine which refresh style to use while asleep: none, CBR or memory self-refresh. In nap, the acknowledge/run line can be re-driven while a bus transaction needs snooping, so that the napping processor answers the snoop. Any exit passes through a single WAKE cycle before RUN. An exit from sleep clears the power-management bit.

Top module: `lp_handshake_ctrl`

## Requirements
- R1: While `rstN` is low, and after it is released, `pwrState` is RUN (0), and `ackRun`, `pmBit`, `refreshCbr` and `refreshSelf` are all low.
- R2: A one-cycle `pmSetReq` pulse sets `pmBit` at the next edge. From RUN, the block leaves only if `pmBit` is set and `quiesceReq` or `haltReq` is high. It goes to NAP_PENDING (1) when `cfgSleepSel` is 0 and to SLEEP_PENDING (3) when it is 1. If `pmBit` is clear, the block stays in RUN.
- R3: In a pending state, `ackRun` stays low while `bridgeIdle` is low. It rises at the edge after `bridgeIdle` is sampled high.
- R4: At the edge after `ackRun` was high in a pending state, the block enters NAP (2) or SLEEP (4), and `ackRun` drops at that same edge. A low-power state is never entered without that acknowledge.
- R5: In NAP, the block moves to WAKE (5) at the next edge when the request (quiesce or halt) falls or a wake event occurs. WAKE always lasts exactly one cycle and is followed by RUN.
- R6: In SLEEP, `busReq0` always wakes the block. `busReq1` wakes it only when `cfgReq1WakeEn` is 1, and `nmi` only when `cfgNmiWakeEn` is 1. A source that is masked leaves the block in SLEEP with `ackRun` low.
- R7: `pmBit` is cleared at the edge that leaves SLEEP. A nap exit leaves `pmBit` set.
- R8: In NAP with `cfgNoForcedRun` = 0, `ackRun` follows `snoopNeeded` in the same cycle. With `cfgNoForcedRun` = 1, or in any state other than NAP, `snoopNeeded` does not raise `ackRun`.
- R9: In SLEEP, `cfgLpRefEn` = 0 keeps both refresh selects low. `cfgLpRefEn` = 1 with `cfgSelfRefEn` = 1 raises only `refreshSelf`, and with `cfgSelfRefEn` = 0 raises only `refreshCbr`. Outside SLEEP, both selects are low.
- R10: A wake event seen in a pending state sends the block to WAKE. Any wake event leaves `ackRun` low from the next edge on.
- R11: Hard reset (`rstN` low, asynchronous) returns the block from SLEEP to RUN at once and clears `pmBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| quiesceReq | input | 1 | Processor quiesce request |
| haltReq | input | 1 | Processor halt indication |
| busReq0 | input | 1 | Bus request of the first requester (always a wake source) |
| busReq1 | input | 1 | Bus request of the second requester |
| nmi | input | 1 | Non-maskable interrupt |
| bridgeIdle | input | 1 | Bridge is idle and ready for low power |
| snoopNeeded | input | 1 | A bus transaction needs a processor snoop |
| pmSetReq | input | 1 | Software write that sets the power-management bit |
| cfgSleepSel | input | 1 | 0 selects nap, 1 selects sleep |
| cfgReq1WakeEn | input | 1 | Lets `busReq1` wake from sleep |
| cfgNmiWakeEn | input | 1 | Lets `nmi` wake from sleep |
| cfgNoForcedRun | input | 1 | 1 disables re-driving the run line in nap |
| cfgLpRefEn | input | 1 | Keep refreshing memory while asleep |
| cfgSelfRefEn | input | 1 | Use self-refresh instead of CBR while asleep |
| ackRun | output | 1 | Acknowledge / run line to the processor |
| pwrState | output | 3 | State code: 0 RUN, 1 NAP_PENDING, 2 NAP, 3 SLEEP_PENDING, 4 SLEEP, 5 WAKE |
| pmBit | output | 1 | Power-management mode bit |
| refreshCbr | output | 1 | Select CBR refresh during sleep |
| refreshSelf | output | 1 | Select self-refresh during sleep |

## Verification
State changes, the acknowledge edge and `pmBit` updates are registered, so each is due one clock after the inputs that cause it are sampled. The forced-run level and the refresh selects are decoded from the current state, so they are due within the same cycle. The bench drives inputs on the falling edge. It reads registered results one falling edge after the rising edge that produces them, and reads the decoded outputs a nanosecond after it changes an input. Masked wake sources are held for several cycles before the state is read, so a late wake would be seen.

// File: rtl/lp_handshake_pkg.sv
package lp_handshake_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN        = 3'd0,
    ST_NAP_PEND   = 3'd1,
    ST_NAP        = 3'd2,
    ST_SLEEP_PEND = 3'd3,
    ST_SLEEP      = 3'd4,
    ST_WAKE       = 3'd5
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ackSet;
    logic ackClr;
    logic pmClr;
  } dpStrobe_t;

  typedef struct packed {
    logic sleepSel;
    logic req1WakeEn;
    logic nmiWakeEn;
    logic noForcedRun;
    logic lpRefEn;
    logic selfRefEn;
  } pmCfg_t;
endpackage

// File: rtl/lp_hs_control.sv
module lp_hs_control
  import lp_handshake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pmCfg_t    cfg,
  input  logic      quiesceReq,
  input  logic      haltReq,
  input  logic      busReq0,
  input  logic      busReq1,
  input  logic      nmi,
  input  logic      bridgeIdle,
  input  logic      ackHeld,
  input  logic      pmBit,
  output pwrState_e state,
  output dpStrobe_t strobe
);
  pwrState_e stateNext;
  logic lpReq;
  logic wakeEv;

  assign lpReq  = quiesceReq | haltReq;
  assign wakeEv = busReq0 | (busReq1 & cfg.req1WakeEn) | (nmi & cfg.nmiWakeEn);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (pmBit && lpReq) stateNext = cfg.sleepSel ? ST_SLEEP_PEND : ST_NAP_PEND;
      end
      ST_NAP_PEND, ST_SLEEP_PEND: begin
        if (wakeEv || !lpReq) begin
          stateNext     = ST_WAKE;
          strobe.ackClr = 1'b1;
        end else if (ackHeld) begin
          stateNext     = (state == ST_NAP_PEND) ? ST_NAP : ST_SLEEP;
          strobe.ackClr = 1'b1;
        end else if (bridgeIdle) begin
          strobe.ackSet = 1'b1;
        end
      end
      ST_NAP: begin
        if (wakeEv || !lpReq) stateNext = ST_WAKE;
      end
      ST_SLEEP: begin
        if (wakeEv) begin
          stateNext    = ST_WAKE;
          strobe.pmClr = 1'b1;
        end
      end
      ST_WAKE: stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/lp_hs_datapath.sv
module lp_hs_datapath
  import lp_handshake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pmCfg_t    cfg,
  input  pwrState_e state,
  input  dpStrobe_t strobe,
  input  logic      pmSetReq,
  input  logic      snoopNeeded,
  output logic      ackHeld,
  output logic      pmBit,
  output logic      ackRun,
  output logic      refreshCbr,
  output logic      refreshSelf
);
  logic inNap;
  logic inSleep;

  assign inNap   = (state == ST_NAP);
  assign inSleep = (state == ST_SLEEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackHeld <= 1'b0;
      pmBit   <= 1'b0;
    end else begin
      if (strobe.ackClr)      ackHeld <= 1'b0;
      else if (strobe.ackSet) ackHeld <= 1'b1;
      if (strobe.pmClr)       pmBit   <= 1'b0;
      else if (pmSetReq)      pmBit   <= 1'b1;
    end
  end

  assign ackRun      = ackHeld | (inNap & snoopNeeded & ~cfg.noForcedRun);
  assign refreshCbr  = inSleep & cfg.lpRefEn & ~cfg.selfRefEn;
  assign refreshSelf = inSleep & cfg.lpRefEn & cfg.selfRefEn;
endmodule

// File: rtl/lp_handshake_ctrl.sv
module lp_handshake_ctrl
  import lp_handshake_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               quiesceReq,
  input  logic               haltReq,
  input  logic               busReq0,
  input  logic               busReq1,
  input  logic               nmi,
  input  logic               bridgeIdle,
  input  logic               snoopNeeded,
  input  logic               pmSetReq,
  input  logic               cfgSleepSel,
  input  logic               cfgReq1WakeEn,
  input  logic               cfgNmiWakeEn,
  input  logic               cfgNoForcedRun,
  input  logic               cfgLpRefEn,
  input  logic               cfgSelfRefEn,
  output logic               ackRun,
  output logic [STATE_W-1:0] pwrState,
  output logic               pmBit,
  output logic               refreshCbr,
  output logic               refreshSelf
);
  pmCfg_t    cfg;
  pwrState_e state;
  dpStrobe_t strobe;
  logic      ackHeld;

  assign cfg = '{sleepSel: cfgSleepSel, req1WakeEn: cfgReq1WakeEn,
                 nmiWakeEn: cfgNmiWakeEn, noForcedRun: cfgNoForcedRun,
                 lpRefEn: cfgLpRefEn, selfRefEn: cfgSelfRefEn};

  lp_hs_control u_control (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .quiesceReq(quiesceReq), .haltReq(haltReq),
    .busReq0(busReq0), .busReq1(busReq1), .nmi(nmi),
    .bridgeIdle(bridgeIdle), .ackHeld(ackHeld), .pmBit(pmBit),
    .state(state), .strobe(strobe)
  );

  lp_hs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .state(state), .strobe(strobe),
    .pmSetReq(pmSetReq), .snoopNeeded(snoopNeeded),
    .ackHeld(ackHeld), .pmBit(pmBit), .ackRun(ackRun),
    .refreshCbr(refreshCbr), .refreshSelf(refreshSelf)
  );

  assign pwrState = state;
endmodule

// File: rtl/lp_handshake_checker.sv
module lp_handshake_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busReq0,
  input logic       busReq1,
  input logic       nmi,
  input logic       cfgReq1WakeEn,
  input logic       cfgNmiWakeEn,
  input logic       ackRun,
  input logic [2:0] pwrState,
  input logic       pmBit,
  input logic       refreshCbr,
  input logic       refreshSelf
);
  logic wakeSeen;
  assign wakeSeen = busReq0 | (busReq1 & cfgReq1WakeEn) | (nmi & cfgNmiWakeEn);

  assert_stay_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd0 && !pmBit) |=> pwrState == 3'd0);

  assert_ack_before_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrState == 3'd1 || pwrState == 3'd3) && !ackRun) |=> (pwrState != 3'd2 && pwrState != 3'd4));

  assert_wake_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 3'd5 |=> pwrState == 3'd0);

  assert_pm_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd4) |=> (pwrState == 3'd4 || !pmBit));

  assert_refresh_sleep_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 3'd4) |-> (!refreshCbr && !refreshSelf));

  assert_refresh_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({refreshCbr, refreshSelf}));

  assert_wake_drops_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakeSeen |=> !ackRun);
endmodule

bind lp_handshake_ctrl lp_handshake_checker u_checker (
  .clk(clk), .rstN(rstN), .busReq0(busReq0), .busReq1(busReq1), .nmi(nmi),
  .cfgReq1WakeEn(cfgReq1WakeEn), .cfgNmiWakeEn(cfgNmiWakeEn),
  .ackRun(ackRun), .pwrState(pwrState), .pmBit(pmBit),
  .refreshCbr(refreshCbr), .refreshSelf(refreshSelf)
);

// File: tb/lp_handshake_ctrl_bench.sv
module lp_handshake_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic quiesceReq = 0, haltReq = 0, busReq0 = 0, busReq1 = 0, nmi = 0;
  logic bridgeIdle = 0, snoopNeeded = 0, pmSetReq = 0;
  logic cfgSleepSel = 0, cfgReq1WakeEn = 0, cfgNmiWakeEn = 0;
  logic cfgNoForcedRun = 0, cfgLpRefEn = 0, cfgSelfRefEn = 0;
  logic ackRun, pmBit, refreshCbr, refreshSelf;
  logic [2:0] pwrState;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lp_handshake_ctrl u_lp_handshake_ctrl (
    .clk(clk), .rstN(rstN), .quiesceReq(quiesceReq), .haltReq(haltReq),
    .busReq0(busReq0), .busReq1(busReq1), .nmi(nmi), .bridgeIdle(bridgeIdle),
    .snoopNeeded(snoopNeeded), .pmSetReq(pmSetReq), .cfgSleepSel(cfgSleepSel),
    .cfgReq1WakeEn(cfgReq1WakeEn), .cfgNmiWakeEn(cfgNmiWakeEn),
    .cfgNoForcedRun(cfgNoForcedRun), .cfgLpRefEn(cfgLpRefEn),
    .cfgSelfRefEn(cfgSelfRefEn), .ackRun(ackRun), .pwrState(pwrState),
    .pmBit(pmBit), .refreshCbr(refreshCbr), .refreshSelf(refreshSelf)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic armPm();
    pmSetReq = 1; tick(); pmSetReq = 0;
    chk("R2 pmBit set", pmBit, 1);
  endtask

  task automatic testReset();
    chk("R1 state", pwrState, 0);
    chk("R1 ack", ackRun, 0);
    chk("R1 pmBit", pmBit, 0);
    chk("R1 refresh", {refreshCbr, refreshSelf}, 0);
  endtask

  task automatic testNoPm();
    quiesceReq = 1; tick(3);
    chk("R2 no entry without pm bit", pwrState, 0);
    quiesceReq = 0; tick();
  endtask

  task automatic testNap();
    armPm();
    cfgSleepSel = 0; bridgeIdle = 0; haltReq = 1; tick();
    chk("R2 nap pending", pwrState, 1);
    tick(3);
    chk("R3 ack low while busy", ackRun, 0);
    chk("R3 still pending", pwrState, 1);
    bridgeIdle = 1; tick();
    chk("R3 ack after idle", ackRun, 1);
    tick();
    chk("R4 nap entered", pwrState, 2);
    chk("R4 ack dropped", ackRun, 0);
    cfgNoForcedRun = 0; snoopNeeded = 1; #1;
    chk("R8 forced run in nap", ackRun, 1);
    cfgNoForcedRun = 1; #1;
    chk("R8 forced run disabled", ackRun, 0);
    snoopNeeded = 0; cfgNoForcedRun = 0; tick(2);
    chk("R5 nap held", pwrState, 2);
    chk("R9 no refresh in nap", {refreshCbr, refreshSelf}, 0);
    haltReq = 0; tick();
    chk("R5 wake after request drop", pwrState, 5);
    chk("R7 pm kept after nap", pmBit, 1);
    tick();
    chk("R5 back to run", pwrState, 0);
    bridgeIdle = 0;
  endtask

  // src: 0 busReq0, 1 busReq1, 2 nmi
  task automatic testSleep(input logic lp, input logic selfRef, input int src);
    armPm();
    cfgLpRefEn = lp; cfgSelfRefEn = selfRef;
    cfgSleepSel = 1; bridgeIdle = 1; quiesceReq = 1; tick();
    chk("R2 sleep pending", pwrState, 3);
    tick();
    chk("R3 ack in sleep pending", ackRun, 1);
    tick();
    chk("R4 sleep entered", pwrState, 4);
    chk("R9 cbr select", refreshCbr, lp & ~selfRef);
    chk("R9 self select", refreshSelf, lp & selfRef);
    snoopNeeded = 1; #1;
    chk("R8 no forced run in sleep", ackRun, 0);
    snoopNeeded = 0;
    cfgReq1WakeEn = 0; cfgNmiWakeEn = 0; busReq1 = 1; nmi = 1; tick(3);
    chk("R6 masked sources ignored", pwrState, 4);
    chk("R6 ack low in sleep", ackRun, 0);
    busReq1 = 0; nmi = 0;
    if (src == 0) busReq0 = 1;
    else if (src == 1) begin cfgReq1WakeEn = 1; busReq1 = 1; end
    else begin cfgNmiWakeEn = 1; nmi = 1; end
    tick();
    chk("R6 wake from sleep", pwrState, 5);
    chk("R7 pm cleared on sleep exit", pmBit, 0);
    busReq0 = 0; busReq1 = 0; nmi = 0; quiesceReq = 0;
    cfgReq1WakeEn = 0; cfgNmiWakeEn = 0; tick();
    chk("R5 run after sleep", pwrState, 0);
    chk("R9 refresh off in run", {refreshCbr, refreshSelf}, 0);
    bridgeIdle = 0;
  endtask

  task automatic testPendWake();
    armPm();
    cfgSleepSel = 0; bridgeIdle = 1; quiesceReq = 1; tick();
    chk("R2 pending for wake test", pwrState, 1);
    tick();
    chk("R3 ack up", ackRun, 1);
    busReq0 = 1; tick();
    chk("R10 wake drops ack", ackRun, 0);
    chk("R10 pending to wake", pwrState, 5);
    busReq0 = 0; quiesceReq = 0; bridgeIdle = 0; tick();
    chk("R5 run after pending wake", pwrState, 0);
  endtask

  task automatic testHardReset();
    armPm();
    cfgSleepSel = 1; bridgeIdle = 1; quiesceReq = 1; tick(3);
    chk("R11 in sleep before reset", pwrState, 4);
    rstN = 0; #1;
    chk("R11 reset to run", pwrState, 0);
    chk("R11 pm cleared", pmBit, 0);
    quiesceReq = 0; bridgeIdle = 0; tick();
    rstN = 1; tick();
    chk("R1 run after reset", pwrState, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    testReset();
    rstN = 1; tick();
    testReset();
    testNoPm();
    testNap();
    testSleep(1'b0, 1'b0, 0);
    testSleep(1'b1, 1'b1, 1);
    testSleep(1'b1, 1'b0, 2);
    testPendWake();
    testHardReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule